// File: doc/BRIEF.md
# Masked Vector Load/Store Unit

This unit moves one 256-bit vector between a register-side request and a byte-addressed memory whose port is 128 bits wide. Each request carries a direction (load or store), an element width of 32 or 64 bits, a byte address, a per-element select mask and, for stores, the vector data. Every element has one select bit. On a load, unselected elements come back as zero. On a store, memory under unselected elements is left untouched.

The start address may be any byte address. The unit places the vector in a window of three aligned 16-byte lines and walks those lines from the lowest upward. A line that holds no byte of a selected element gets no memory beat. A request whose mask selects nothing completes almost at once and touches no memory.

The memory is synchronous: read data appears the cycle after a read beat is presented. Completion is one `rsp_done` pulse. For a load, `rsp_data` carries the result during that pulse. For a store, `rsp_data` is zero.

Top module: `vmask_lsu`

## Requirements
- R1: `req_wide`=0 selects 32-bit elements, eight per vector, with mask bit i controlling bytes 4i..4i+3. `req_wide`=1 selects 64-bit elements, four per vector, with mask bit i controlling bytes 8i..8i+7, and mask bits 7..4 have no effect. Byte k of the vector is memory byte `req_addr`+k (element 0 is lowest).
- R2: On a load, every byte of an unselected element reads as zero in `rsp_data`.
- R3: A read beat is issued only for a line that holds at least one byte of a selected element. Loads never assert any write enable.
- R4: On a store, only bytes of selected elements have their write enables asserted. All other memory bytes keep their value.
- R5: When no element is selected, the unit issues no memory beat, and `rsp_done` rises two clock edges after the accepting edge.
- R6: Any byte address is accepted. The access is split into aligned 16-byte beats with `mem_line` = address/16. Beats issue in strictly ascending line order, and each line that holds selected bytes is accessed exactly once.
- R7: `req_ready` is high only when the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `rsp_done` is a single-cycle pulse, and `req_ready` is high during that cycle.
- R8: After synchronous reset, `req_ready`=1, `rsp_done`=0, `mem_re`=0 and `mem_we`=0.
- R9: On a load, every byte of a selected element in `rsp_data` equals the memory byte at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wide | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| req_addr | input | ADDR_W | Byte address of vector byte 0 |
| req_mask | input | VEC_BYTES/4 | Element select bits |
| req_wdata | input | VEC_BYTES*8 | Store vector |
| mem_re | output | 1 | Read beat |
| mem_we | output | LINE_BYTES | Per-byte write enables |
| mem_line | output | ADDR_W-log2(LINE_BYTES) | Aligned line address |
| mem_wdata | output | LINE_BYTES*8 | Write data for the line |
| mem_rdata | input | LINE_BYTES*8 | Read data, one cycle after the read beat |
| rsp_done | output | 1 | Completion pulse |
| rsp_data | output | VEC_BYTES*8 | Load result, valid with rsp_done |

## Verification
Two functions can fall in the same cycle: completion of one request and acceptance of the next, because `req_ready` is high during the `rsp_done` cycle. The bench presents each next request in the very cycle it sees the pulse, so every operation of the sweep starts back to back with the end of the previous one. After each handoff, it judges the new operation by its beat count, the enable-to-select correspondence, ascending line order and the resulting data or memory image. A leftover window, offset or mask from the earlier request would show up as a wrong byte or an extra beat.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_RESP  = 2'd3
  } lsu_state_e;

  typedef enum logic {
    ESZ_W32 = 1'b0,
    ESZ_W64 = 1'b1
  } elem_size_e;
endpackage

// File: rtl/vmask_bytemask.sv
module vmask_bytemask
  import vmask_pkg::*;
#(
  parameter int VEC_BYTES = 32,
  parameter int MASK_W    = VEC_BYTES / 4
) (
  input  logic [MASK_W-1:0]    mask,
  input  elem_size_e           esz,
  output logic [VEC_BYTES-1:0] byte_en
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    assign byte_en[b] = (esz == ESZ_W64) ? mask[b / 8] : mask[b / 4];
  end
endmodule

// File: rtl/vmask_beat_sched.sv
module vmask_beat_sched
  import vmask_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int NUM_BEATS  = 3,
  parameter int LINE_AW    = 8,
  localparam int WIN_BYTES = LINE_BYTES * NUM_BEATS,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WIN_W     = WIN_BYTES * 8,
  localparam int IDX_W     = $clog2(NUM_BEATS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  empty,
  input  logic                  store_in,
  input  logic [LINE_AW-1:0]    base_in,
  input  logic [WIN_BYTES-1:0]  win_en_in,
  input  logic [WIN_W-1:0]      win_wdata_in,
  output logic                  ready,
  output logic                  mem_re,
  output logic [LINE_BYTES-1:0] mem_we,
  output logic [LINE_AW-1:0]    mem_line,
  output logic [LINE_W-1:0]     mem_wdata,
  output logic                  cap_vld,
  output logic [IDX_W-1:0]      cap_idx,
  output logic                  fire,
  output logic                  fire_store
);
  lsu_state_e             st_q;
  logic [IDX_W-1:0]       idx_q;
  logic                   drain_q;
  logic                   store_q;
  logic [LINE_AW-1:0]     base_q;
  logic [WIN_BYTES-1:0]   en_q;
  logic [WIN_W-1:0]       wd_q;
  logic                   re_q;
  logic [LINE_BYTES-1:0]  we_q;
  logic [LINE_AW-1:0]     line_q;
  logic [LINE_W-1:0]      wdat_q;
  logic [IDX_W-1:0]       rd_idx_q;
  logic                   pend_q;
  logic [IDX_W-1:0]       pend_idx_q;
  logic [LINE_BYTES-1:0]  cur_en;
  logic [LINE_W-1:0]      cur_wd;
  logic                   mem_act;

  assign cur_en = en_q[int'(idx_q) * LINE_BYTES +: LINE_BYTES];
  assign cur_wd = wd_q[int'(idx_q) * LINE_W +: LINE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      drain_q    <= 1'b0;
      store_q    <= 1'b0;
      base_q     <= '0;
      en_q       <= '0;
      wd_q       <= '0;
      re_q       <= 1'b0;
      we_q       <= '0;
      line_q     <= '0;
      wdat_q     <= '0;
      rd_idx_q   <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      pend_q     <= re_q;
      pend_idx_q <= rd_idx_q;
      re_q       <= 1'b0;
      we_q       <= '0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            store_q <= store_in;
            base_q  <= base_in;
            en_q    <= win_en_in;
            wd_q    <= win_wdata_in;
            idx_q   <= '0;
            st_q    <= empty ? ST_RESP : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (|cur_en) begin
            re_q     <= !store_q;
            we_q     <= store_q ? cur_en : '0;
            line_q   <= base_q + LINE_AW'(idx_q);
            wdat_q   <= cur_wd;
            rd_idx_q <= idx_q;
          end
          if (idx_q == IDX_W'(NUM_BEATS - 1)) begin
            st_q    <= ST_DRAIN;
            drain_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drain_q) drain_q <= 1'b0;
          else         st_q    <= ST_RESP;
        end
        ST_RESP:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready      = (st_q == ST_IDLE);
  assign fire       = (st_q == ST_RESP);
  assign fire_store = store_q;
  assign mem_re     = re_q;
  assign mem_we     = we_q;
  assign mem_line   = line_q;
  assign mem_wdata  = wdat_q;
  assign cap_vld    = pend_q;
  assign cap_idx    = pend_idx_q;
  assign mem_act    = re_q || (|we_q);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (!re_q && we_q == '0));

  assert_ascend_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_act && $past(mem_act)) |-> (line_q == $past(line_q) + LINE_AW'(1)));

  assert_no_mix_R3: assert property (@(posedge clk) disable iff (rst)
    !(re_q && (|we_q)));
endmodule

// File: rtl/vmask_load_merge.sv
module vmask_load_merge #(
  parameter int VEC_BYTES  = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_BEATS  = 3,
  localparam int VEC_W     = VEC_BYTES * 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WIN_W     = LINE_W * NUM_BEATS,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(NUM_BEATS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [OFF_W-1:0]     off_in,
  input  logic [VEC_BYTES-1:0] byte_en_in,
  input  logic                 cap_vld,
  input  logic [IDX_W-1:0]     cap_idx,
  input  logic [LINE_W-1:0]    mem_rdata,
  input  logic                 fire,
  input  logic                 fire_store,
  output logic                 rsp_done,
  output logic [VEC_W-1:0]     rsp_data
);
  logic [WIN_W-1:0]     win_q;
  logic [OFF_W-1:0]     off_q;
  logic [VEC_BYTES-1:0] ben_q;
  logic [VEC_W-1:0]     vec_sh;
  logic [VEC_W-1:0]     picked;
  logic                 done_q;
  logic [VEC_W-1:0]     data_q;

  assign vec_sh = VEC_W'(win_q >> {off_q, 3'b000});

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_pick
    assign picked[b*8 +: 8] = ben_q[b] ? vec_sh[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      off_q  <= '0;
      ben_q  <= '0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (start) begin
        off_q <= off_in;
        ben_q <= byte_en_in;
      end
      if (cap_vld) win_q[int'(cap_idx) * LINE_W +: LINE_W] <= mem_rdata;
      done_q <= fire;
      if (fire) data_q <= fire_store ? '0 : picked;
    end
  end

  assign rsp_done = done_q;
  assign rsp_data = data_q;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/vmask_lsu.sv
module vmask_lsu
  import vmask_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int VEC_BYTES  = 32,
  parameter int LINE_BYTES = 16,
  localparam int MASK_W    = VEC_BYTES / 4,
  localparam int VEC_W     = VEC_BYTES * 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_AW   = ADDR_W - OFF_W,
  localparam int NUM_BEATS = VEC_BYTES / LINE_BYTES + 1,
  localparam int WIN_BYTES = NUM_BEATS * LINE_BYTES,
  localparam int WIN_W     = WIN_BYTES * 8,
  localparam int IDX_W     = $clog2(NUM_BEATS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_store,
  input  logic                  req_wide,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [MASK_W-1:0]     req_mask,
  input  logic [VEC_W-1:0]      req_wdata,
  output logic                  mem_re,
  output logic [LINE_BYTES-1:0] mem_we,
  output logic [LINE_AW-1:0]    mem_line,
  output logic [LINE_W-1:0]     mem_wdata,
  input  logic [LINE_W-1:0]     mem_rdata,
  output logic                  rsp_done,
  output logic [VEC_W-1:0]      rsp_data
);
  logic [VEC_BYTES-1:0] byte_en;
  logic                 start;
  logic                 empty;
  logic [OFF_W-1:0]     off;
  logic [LINE_AW-1:0]   base;
  logic [WIN_BYTES-1:0] win_en;
  logic [WIN_W-1:0]     win_wdata;
  logic                 cap_vld;
  logic [IDX_W-1:0]     cap_idx;
  logic                 fire;
  logic                 fire_store;

  vmask_bytemask #(.VEC_BYTES(VEC_BYTES), .MASK_W(MASK_W)) u_bytemask (
    .mask    (req_mask),
    .esz     (elem_size_e'(req_wide)),
    .byte_en (byte_en)
  );

  assign start     = req_valid && req_ready;
  assign empty     = ~|byte_en;
  assign off       = req_addr[OFF_W-1:0];
  assign base      = req_addr[ADDR_W-1:OFF_W];
  assign win_en    = WIN_BYTES'(byte_en) << off;
  assign win_wdata = WIN_W'(req_wdata) << {off, 3'b000};

  vmask_beat_sched #(
    .LINE_BYTES (LINE_BYTES),
    .NUM_BEATS  (NUM_BEATS),
    .LINE_AW    (LINE_AW)
  ) u_sched (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .empty        (empty),
    .store_in     (req_store),
    .base_in      (base),
    .win_en_in    (win_en),
    .win_wdata_in (win_wdata),
    .ready        (req_ready),
    .mem_re       (mem_re),
    .mem_we       (mem_we),
    .mem_line     (mem_line),
    .mem_wdata    (mem_wdata),
    .cap_vld      (cap_vld),
    .cap_idx      (cap_idx),
    .fire         (fire),
    .fire_store   (fire_store)
  );

  vmask_load_merge #(
    .VEC_BYTES  (VEC_BYTES),
    .LINE_BYTES (LINE_BYTES),
    .NUM_BEATS  (NUM_BEATS)
  ) u_merge (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .off_in     (off),
    .byte_en_in (byte_en),
    .cap_vld    (cap_vld),
    .cap_idx    (cap_idx),
    .mem_rdata  (mem_rdata),
    .fire       (fire),
    .fire_store (fire_store),
    .rsp_done   (rsp_done),
    .rsp_data   (rsp_data)
  );

  assert_zero_fast_R5: assert property (@(posedge clk) disable iff (rst)
    (start && empty) |-> ##2 rsp_done);

  assert_zero_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (start && empty) |=> (!mem_re && mem_we == '0));

  assert_done_ready_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);
endmodule

// File: tb/vmask_lsu_tb_top.sv
module vmask_lsu_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst;
  logic         req_valid, req_ready, req_store, req_wide;
  logic [11:0]  req_addr;
  logic [7:0]   req_mask;
  logic [255:0] req_wdata;
  logic         mem_re;
  logic [15:0]  mem_we;
  logic [7:0]   mem_line;
  logic [127:0] mem_wdata, mem_rdata;
  logic         rsp_done;
  logic [255:0] rsp_data;

  vmask_lsu dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_wide(req_wide), .req_addr(req_addr),
    .req_mask(req_mask), .req_wdata(req_wdata), .mem_re(mem_re),
    .mem_we(mem_we), .mem_line(mem_line), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  logic [7:0] mem     [0:4095];
  logic [7:0] ref_mem [0:4095];
  bit         sel     [0:4095];
  int n_tests = 0, n_fail = 0;
  int acc_cnt, bad_cnt, bad_ord, last_line;
  bit have_last;

  initial begin
    for (int a = 0; a < 4096; a++) begin
      mem[a]     = 8'((a * 37 + 5) ^ (a >> 4));
      ref_mem[a] = 8'((a * 37 + 5) ^ (a >> 4));
      sel[a]     = 1'b0;
    end
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    for (int j = 0; j < 16; j++) begin
      if (mem_re) mem_rdata[j*8 +: 8] <= mem[int'(mem_line) * 16 + j];
      if (mem_we[j]) mem[int'(mem_line) * 16 + j] <= mem_wdata[j*8 +: 8];
    end
  end

  always @(negedge clk) begin
    if (!rst && (mem_re || (|mem_we))) begin
      bit any;
      acc_cnt++;
      if (have_last && int'(mem_line) <= last_line) bad_ord++;
      last_line = int'(mem_line);
      have_last = 1'b1;
      any = 1'b0;
      for (int j = 0; j < 16; j++) begin
        if (sel[int'(mem_line) * 16 + j]) any = 1'b1;
        if (mem_we[j] && !sel[int'(mem_line) * 16 + j]) bad_cnt++;
      end
      if (mem_re && !any) bad_cnt++;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit st, input bit wide, input int addr,
                       input logic [7:0] mask, input int seed);
    logic [255:0] wd, exp;
    int n, lines, mism, e;
    bit any;
    for (int b = 0; b < 32; b++) begin
      e = wide ? b / 8 : b / 4;
      sel[addr + b]     = mask[e];
      wd[b*8 +: 8]      = 8'(seed * 7 + b * 13 + 1);
      exp[b*8 +: 8]     = mask[e] ? ref_mem[addr + b] : 8'h00;
    end
    lines = 0;
    for (int l = addr / 16; l <= (addr + 31) / 16; l++) begin
      any = 1'b0;
      for (int j = 0; j < 16; j++) if (sel[l * 16 + j]) any = 1'b1;
      if (any) lines++;
    end
    acc_cnt = 0; bad_cnt = 0; bad_ord = 0; have_last = 1'b0;
    req_store = st; req_wide = wide; req_addr = 12'(addr);
    req_mask = mask; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!rsp_done && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(rsp_done, "R7 done pulse seen", 256'(n), 256'(0));
    if (lines == 0)
      check(n == 2, wide ? "R1/R5 empty-mask latency" : "R5 empty-mask latency",
            256'(n), 256'(2));
    check(acc_cnt == lines, wide ? "R1/R6 beat count" : "R6/R3 beat count",
          256'(acc_cnt), 256'(lines));
    check(bad_cnt == 0, st ? "R4 write enable outside selection" : "R3 read of unselected line",
          256'(bad_cnt), 256'(0));
    check(bad_ord == 0, "R6 ascending beats", 256'(bad_ord), 256'(0));
    if (!st) begin
      check(rsp_data == exp, "R2/R9 load data", rsp_data, exp);
    end else begin
      for (int b = 0; b < 32; b++) if (sel[addr + b]) ref_mem[addr + b] = wd[b*8 +: 8];
      mism = 0;
      for (int a = addr - 16; a < addr + 48; a++) if (mem[a] !== ref_mem[a]) mism++;
      check(mism == 0, "R4 store memory image", 256'(mism), 256'(0));
    end
    for (int b = 0; b < 32; b++) sel[addr + b] = 1'b0;
  endtask

  initial begin
    int k;
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_wide = 1'b0;
    req_addr = '0; req_mask = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready after reset", 256'(req_ready), 256'(1));
    check(rsp_done == 1'b0, "R8 done after reset", 256'(rsp_done), 256'(0));
    check(!mem_re && mem_we == '0, "R8 memory idle after reset",
          256'({mem_re, mem_we}), 256'(0));
    k = 0;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        for (int off = 0; off < 16; off++)
          for (int m = 0; m < (w != 0 ? 32 : 256); m++) begin
            do_op(s[0], w[0], 16 * (1 + (k % 200)) + off, 8'(m), k);
            k++;
          end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired actual=hung expected=complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule